// File: doc/BRIEF.md
# Signed and Unsigned Integer Divide Unit

This block is a multi-cycle integer divider shared by three divide operations: a signed 16-by-16 divide, an unsigned 32-by-16 extended divide, and a signed 32-by-16 extended divide. The instruction sequencer pulses `start` with an operation code and the current values of the three 16-bit working registers (accumulator pair D, index X, index Y) and of the N, Z and V condition flags. The unit then runs a restoring shift-subtract loop that produces one quotient bit per clock. When it completes, it returns the new register values and the four condition flags together with a single-cycle `done` pulse.

Signed operands are converted to magnitudes before the loop. The signs are restored on the quotient and remainder after the loop. Quotients truncate toward zero, and a remainder takes the sign of the dividend. A zero divisor skips the loop, sets the carry flag, and hands back every register and the remaining flags exactly as they were received.

Top module: `divUnit`

## Requirements
- R1: Operation code 0 is the signed short divide. D is the dividend and X the divisor, both two's complement. The quotient, truncated toward zero, is returned on `outX`. The remainder is returned on `outD` and has the sign of the dividend. `outY` equals the received Y.
- R2: Operation code 1 is the unsigned extended divide. The dividend is {Y,D} with Y as the upper half, and X is the divisor. The low 16 bits of the quotient are returned on `outY` and the remainder on `outD`. `outX` equals the received X.
- R3: Operation codes 2 and 3 are the signed extended divide. It uses the same operand and result placement as R2 but treats {Y,D} and X as two's complement. It truncates toward zero, and the remainder has the sign of the dividend.
- R4: When the divisor is zero, `flagC` is 1. `outD`, `outX` and `outY` equal the received D, X and Y. `flagN`, `flagZ` and `flagV` equal `nIn`, `zIn` and `vIn`.
- R5: When the divisor is nonzero, `flagC` is 0. `flagZ` is 1 exactly when the full quotient is zero. `flagN` equals bit 15 of the quotient in two's complement.
- R6: In the unsigned extended divide, `flagV` is 1 exactly when the quotient exceeds 65535.
- R7: In both signed divides, `flagV` is 1 exactly when the quotient lies outside -32768..32767. When `flagV` is 1, the register outputs carry no defined value.
- R8: `done` is high for exactly one cycle. It rises 1 clock edge after the edge that accepts `start` when the divisor is zero. Otherwise it rises 17 edges after that edge for code 0 and 33 edges after it for codes 1 to 3.
- R9: `busy` is high from the edge that accepts `start` until the edge that raises `done`, and it is low while `done` is high. A `start` seen while `busy` is high is ignored and does not change the pending result.
- R10: During reset, `busy` and `done` are 0, and all register outputs and flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a divide; accepted only while idle |
| op | input | 2 | Operation code: 0 signed short, 1 unsigned extended, 2 or 3 signed extended |
| regD | input | 16 | Received D register (dividend or its low half) |
| regX | input | 16 | Received X register (divisor) |
| regY | input | 16 | Received Y register (dividend high half for extended divides) |
| zIn | input | 1 | Current Z flag, returned on a zero divisor |
| nIn | input | 1 | Current N flag, returned on a zero divisor |
| vIn | input | 1 | Current V flag, returned on a zero divisor |
| busy | output | 1 | Divide in progress |
| done | output | 1 | One-cycle completion pulse; results valid from here on |
| outD | output | 16 | New D value |
| outX | output | 16 | New X value |
| outY | output | 16 | New Y value |
| flagC | output | 1 | Carry flag: divide by zero |
| flagZ | output | 1 | Zero-quotient flag |
| flagN | output | 1 | Quotient bit 15 |
| flagV | output | 1 | Quotient overflow |

## Verification
The bound checker examines every completion on every cycle. It checks the single-cycle `done` pulse, the latency measured against its own count of edges since the accepted start, and `busy` rising after acceptance and falling by the `done` cycle. It also checks the zero-divisor pass-through of registers and flags, the unchanged pass-through register for each operation, and that Z and N agree with the returned quotient whenever no overflow occurs. The arithmetic itself can only be shown by the bench's scenarios, which compare quotient and remainder values against a behavioural integer model. These scenarios cover sign combinations under truncation toward zero, the overflow boundaries of both the signed and unsigned forms, operation code 3, and a start pulse injected mid-operation.

// File: rtl/divPkg.sv
`timescale 1ns/1ps
package divPkg;

  typedef enum logic [1:0] {
    OP_SDIV16  = 2'd0,
    OP_UDIV32  = 2'd1,
    OP_SDIV32  = 2'd2,
    OP_SDIV32B = 2'd3
  } divOpE;

  // control-to-datapath strobes
  typedef struct packed {
    logic load;
    logic step;
    logic finish;
  } divStrobeS;

endpackage

// File: rtl/divCtrl.sv
`timescale 1ns/1ps
module divCtrl
  import divPkg::*;
#(
  parameter int W = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [1:0] op,
  input  logic       divZero,
  output divStrobeS  strobe,
  output logic       busy,
  output logic       done
);

  localparam int SHORT_ITERS = W;
  localparam int LONG_ITERS  = 2 * W;
  localparam int CW          = $clog2(LONG_ITERS + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} stateE;

  stateE         state;
  logic [CW-1:0] iterLeft;
  logic          accept;

  assign accept = start && (state == ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      iterLeft <= '0;
      done     <= 1'b0;
    end else begin
      done <= (state == ST_FIN);
      case (state)
        ST_IDLE: begin
          if (accept) begin
            if (divZero) begin
              state <= ST_FIN;
            end else begin
              state    <= ST_RUN;
              iterLeft <= (op == OP_SDIV16) ? CW'(SHORT_ITERS) : CW'(LONG_ITERS);
            end
          end
        end
        ST_RUN: begin
          iterLeft <= iterLeft - 1'b1;
          if (iterLeft == CW'(1)) state <= ST_FIN;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy          = (state != ST_IDLE);
  assign strobe.load   = accept;
  assign strobe.step   = (state == ST_RUN);
  assign strobe.finish = (state == ST_FIN);

endmodule

// File: rtl/divDatapath.sv
`timescale 1ns/1ps
module divDatapath
  import divPkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  divStrobeS    strobe,
  input  logic [1:0]   op,
  input  logic [W-1:0] regD,
  input  logic [W-1:0] regX,
  input  logic [W-1:0] regY,
  input  logic         zIn,
  input  logic         nIn,
  input  logic         vIn,
  output logic         divZero,
  output logic [W-1:0] outD,
  output logic [W-1:0] outX,
  output logic [W-1:0] outY,
  output logic         flagC,
  output logic         flagZ,
  output logic         flagN,
  output logic         flagV
);

  localparam int DW = 2 * W;

  // operands captured at load
  logic [W-1:0]  keepD, keepX, keepY;
  logic          keepZ, keepN, keepV;
  logic          shortOp, signedOp, negQuot, negRem;
  logic [W-1:0]  divMag;
  // iteration state: dividend/quotient shifter and partial remainder
  logic [DW-1:0] dq;
  logic [W-1:0]  rem;

  // load-side combinational values
  logic [DW-1:0] dividendIn, dividendMag;
  logic [W-1:0]  divisorMag;
  logic          sgnIn, dividendNeg, divisorNeg, shortIn;

  always_comb begin
    shortIn     = (op == OP_SDIV16);
    sgnIn       = (op != OP_UDIV32);
    dividendIn  = shortIn ? {{W{regD[W-1]}}, regD} : {regY, regD};
    dividendNeg = sgnIn & dividendIn[DW-1];
    dividendMag = dividendNeg ? -dividendIn : dividendIn;
    divisorNeg  = sgnIn & regX[W-1];
    divisorMag  = divisorNeg ? -regX : regX;
  end

  assign divZero = (regX == '0);

  // one restoring step
  logic [W:0] trial;
  assign trial = {rem, dq[DW-1]} - {1'b0, divMag};

  // result-side combinational values
  logic [DW:0]  quotSigned;
  logic [W-1:0] remSigned;
  logic [DW-W+1:0] upperBits;
  logic         quotOvf;

  always_comb begin
    quotSigned = negQuot ? -{1'b0, dq} : {1'b0, dq};
    remSigned  = negRem ? -rem : rem;
    upperBits  = quotSigned[DW:W-1];
    quotOvf    = signedOp ? !((&upperBits) || !(|upperBits))
                          : (|dq[DW-1:W]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keepD <= '0; keepX <= '0; keepY <= '0;
      keepZ <= 1'b0; keepN <= 1'b0; keepV <= 1'b0;
      shortOp <= 1'b0; signedOp <= 1'b0; negQuot <= 1'b0; negRem <= 1'b0;
      divMag <= '0; dq <= '0; rem <= '0;
      outD <= '0; outX <= '0; outY <= '0;
      flagC <= 1'b0; flagZ <= 1'b0; flagN <= 1'b0; flagV <= 1'b0;
    end else begin
      if (strobe.load) begin
        keepD    <= regD;
        keepX    <= regX;
        keepY    <= regY;
        keepZ    <= zIn;
        keepN    <= nIn;
        keepV    <= vIn;
        shortOp  <= shortIn;
        signedOp <= sgnIn;
        negQuot  <= dividendNeg ^ divisorNeg;
        negRem   <= dividendNeg;
        divMag   <= divisorMag;
        dq       <= shortIn ? {dividendMag[W-1:0], {W{1'b0}}} : dividendMag;
        rem      <= '0;
      end
      if (strobe.step) begin
        if (!trial[W]) begin
          rem <= trial[W-1:0];
          dq  <= {dq[DW-2:0], 1'b1};
        end else begin
          rem <= {rem[W-2:0], dq[DW-1]};
          dq  <= {dq[DW-2:0], 1'b0};
        end
      end
      if (strobe.finish) begin
        if (divMag == '0) begin
          outD  <= keepD;
          outX  <= keepX;
          outY  <= keepY;
          flagC <= 1'b1;
          flagZ <= keepZ;
          flagN <= keepN;
          flagV <= keepV;
        end else begin
          outD  <= remSigned;
          outX  <= shortOp ? quotSigned[W-1:0] : keepX;
          outY  <= shortOp ? keepY : quotSigned[W-1:0];
          flagC <= 1'b0;
          flagZ <= (dq == '0);
          flagN <= quotSigned[W-1];
          flagV <= quotOvf;
        end
      end
    end
  end

endmodule

// File: rtl/divUnit.sv
`timescale 1ns/1ps
module divUnit
  import divPkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] regD,
  input  logic [W-1:0] regX,
  input  logic [W-1:0] regY,
  input  logic         zIn,
  input  logic         nIn,
  input  logic         vIn,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] outD,
  output logic [W-1:0] outX,
  output logic [W-1:0] outY,
  output logic         flagC,
  output logic         flagZ,
  output logic         flagN,
  output logic         flagV
);

  divStrobeS strobe;
  logic      divZero;

  divCtrl #(.W(W)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .op(op), .divZero(divZero),
    .strobe(strobe), .busy(busy), .done(done)
  );

  divDatapath #(.W(W)) path_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .op(op),
    .regD(regD), .regX(regX), .regY(regY),
    .zIn(zIn), .nIn(nIn), .vIn(vIn), .divZero(divZero),
    .outD(outD), .outX(outX), .outY(outY),
    .flagC(flagC), .flagZ(flagZ), .flagN(flagN), .flagV(flagV)
  );

endmodule

// File: rtl/divUnitChecker.sv
`timescale 1ns/1ps
module divUnitChecker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rstN,
  input logic         start,
  input logic [1:0]   op,
  input logic [W-1:0] regD,
  input logic [W-1:0] regX,
  input logic [W-1:0] regY,
  input logic         zIn,
  input logic         nIn,
  input logic         vIn,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] outD,
  input logic [W-1:0] outX,
  input logic [W-1:0] outY,
  input logic         flagC,
  input logic         flagZ,
  input logic         flagN,
  input logic         flagV
);

  localparam int CNTW = $clog2(2 * W + 2) + 1;

  logic [1:0]      capOp;
  logic [W-1:0]    capD, capX, capY;
  logic            capZ, capN, capV;
  logic [CNTW-1:0] edgesSince;
  logic [CNTW-1:0] expLat;
  logic            capZeroDiv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capOp <= '0; capD <= '0; capX <= '0; capY <= '0;
      capZ <= 1'b0; capN <= 1'b0; capV <= 1'b0;
      edgesSince <= '0;
    end else if (start && !busy) begin
      capOp <= op; capD <= regD; capX <= regX; capY <= regY;
      capZ <= zIn; capN <= nIn; capV <= vIn;
      edgesSince <= '0;
    end else if (busy) begin
      edgesSince <= edgesSince + 1'b1;
    end
  end

  assign capZeroDiv = (capX == '0);
  assign expLat = capZeroDiv ? CNTW'(1)
                : (capOp == 2'd0) ? CNTW'(W + 1) : CNTW'(2 * W + 1);

  assert_single_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_latency_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> edgesSince == expLat);
  assert_busy_after_start_R9: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);
  assert_idle_at_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  assert_zero_passthru_R4: assert property (@(posedge clk) disable iff (!rstN)
    (done && capZeroDiv) |-> (flagC && outD == capD && outX == capX && outY == capY
                              && flagZ == capZ && flagN == capN && flagV == capV));
  assert_carry_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    (done && !capZeroDiv) |-> !flagC);
  assert_short_keeps_y_R1: assert property (@(posedge clk) disable iff (!rstN)
    (done && capOp == 2'd0) |-> outY == capY);
  assert_ext_keeps_x_R2: assert property (@(posedge clk) disable iff (!rstN)
    (done && capOp != 2'd0) |-> outX == capX);
  assert_zn_short_R5: assert property (@(posedge clk) disable iff (!rstN)
    (done && !flagC && !flagV && capOp == 2'd0)
      |-> (flagZ == (outX == '0) && flagN == outX[W-1]));
  assert_zn_ext_R5: assert property (@(posedge clk) disable iff (!rstN)
    (done && !flagC && !flagV && capOp != 2'd0)
      |-> (flagZ == (outY == '0) && flagN == outY[W-1]));

endmodule

bind divUnit divUnitChecker #(.W(W)) chk_i (
  .clk(clk), .rstN(rstN), .start(start), .op(op),
  .regD(regD), .regX(regX), .regY(regY),
  .zIn(zIn), .nIn(nIn), .vIn(vIn),
  .busy(busy), .done(done),
  .outD(outD), .outX(outX), .outY(outY),
  .flagC(flagC), .flagZ(flagZ), .flagN(flagN), .flagV(flagV)
);

// File: tb/divUnit_tb_top.sv
`timescale 1ns/1ps
module divUnit_tb_top;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [1:0]   op = 2'd0;
  logic [W-1:0] regD = '0, regX = '0, regY = '0;
  logic         zIn = 1'b0, nIn = 1'b0, vIn = 1'b0;
  logic         busy, done, flagC, flagZ, flagN, flagV;
  logic [W-1:0] outD, outX, outY;

  int nChecks = 0;
  int nFail   = 0;

  always #2.5 clk = ~clk;

  divUnit #(.W(W)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .op(op),
    .regD(regD), .regX(regX), .regY(regY),
    .zIn(zIn), .nIn(nIn), .vIn(vIn),
    .busy(busy), .done(done),
    .outD(outD), .outX(outX), .outY(outY),
    .flagC(flagC), .flagZ(flagZ), .flagN(flagN), .flagV(flagV)
  );

  task automatic check(input string tag, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // behavioural reference: integer division on the requirement's operands
  task automatic model(input logic [1:0] o, input logic [15:0] d, x, y,
                       input logic zi, ni, vi,
                       output logic [15:0] eD, eX, eY,
                       output logic eC, eZ, eN, eV);
    longint a, b, q, r;
    if (o == 2'd0) begin
      a = longint'($signed(d));
      b = longint'($signed(x));
    end else if (o == 2'd1) begin
      a = longint'({32'd0, y, d});
      b = longint'({48'd0, x});
    end else begin
      a = longint'($signed({y, d}));
      b = longint'($signed(x));
    end
    if (b == 0) begin
      eD = d; eX = x; eY = y;
      eC = 1'b1; eZ = zi; eN = ni; eV = vi;
    end else begin
      q  = a / b;
      r  = a % b;
      eC = 1'b0;
      eZ = (q == 0);
      eN = q[15];
      eV = (o == 2'd1) ? (q > 65535) : (q > 32767 || q < -32768);
      eD = r[15:0];
      if (o == 2'd0) begin
        eX = q[15:0]; eY = y;
      end else begin
        eX = x; eY = q[15:0];
      end
    end
  endtask

  // run one divide; compare busy/done every cycle, then the results
  task automatic runOp(input logic [1:0] o, input logic [15:0] d, x, y,
                       input logic zi, ni, vi, input string tag, input bit poke);
    logic [15:0] eD, eX, eY;
    logic eC, eZ, eN, eV;
    int lat;
    bit traceOk;
    logic [1:0] actBD, expBD;
    model(o, d, x, y, zi, ni, vi, eD, eX, eY, eC, eZ, eN, eV);
    lat = (x == 16'd0) ? 1 : ((o == 2'd0) ? W + 1 : 2 * W + 1);
    traceOk = 1'b1;
    actBD = '0;
    expBD = '0;
    @(negedge clk);
    op = o; regD = d; regX = x; regY = y; zIn = zi; nIn = ni; vIn = vi;
    start = 1'b1;
    for (int j = 0; j <= lat; j++) begin
      @(negedge clk);
      if (traceOk && ({busy, done} != {(j < lat), (j == lat)})) begin
        traceOk = 1'b0;
        actBD = {busy, done};
        expBD = {(j < lat), (j == lat)};
      end
      start = 1'b0;
      if (poke && j == 2) begin
        // R9: a second start while busy with different operands
        start = 1'b1;
        op = ~o; regD = ~d; regX = 16'h0003; regY = ~y;
      end
    end
    check(poke ? "R9" : "R8", {tag, " busy/done trace"}, longint'(actBD), longint'(expBD));
    check("R4", {tag, " flagC"}, longint'(flagC), longint'(eC));
    check("R7", {tag, " flagV"}, longint'(flagV), longint'(eV));
    check("R5", {tag, " flagZ"}, longint'(flagZ), longint'(eZ));
    check("R5", {tag, " flagN"}, longint'(flagN), longint'(eN));
    if (!eV) begin
      check(tag, "outD", longint'(outD), longint'(eD));
      check(tag, "outX", longint'(outX), longint'(eX));
      check(tag, "outY", longint'(outY), longint'(eY));
    end
  endtask

  initial begin
    #(200000 * 5);
    nChecks++;
    nFail++;
    $display("FAIL R8 watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", "busy", longint'(busy), 0);
    check("R10", "done", longint'(done), 0);
    check("R10", "outputs", longint'({outD, outX, outY}), 0);
    check("R10", "flags", longint'({flagC, flagZ, flagN, flagV}), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1: signed short divide, all sign combinations
    runOp(2'd0, 16'd100, 16'd7, 16'h5A5A, 1'b0, 1'b0, 1'b0, "R1 pos/pos", 1'b0);
    runOp(2'd0, -16'sd100, 16'd7, 16'h1111, 1'b0, 1'b0, 1'b0, "R1 neg/pos", 1'b0);
    runOp(2'd0, 16'd100, -16'sd7, 16'h2222, 1'b0, 1'b0, 1'b0, "R1 pos/neg", 1'b0);
    runOp(2'd0, -16'sd100, -16'sd7, 16'h3333, 1'b0, 1'b0, 1'b0, "R1 neg/neg", 1'b0);
    runOp(2'd0, 16'd0, 16'd5, 16'h0000, 1'b0, 1'b1, 1'b1, "R5 zero quotient", 1'b0);
    runOp(2'd0, 16'h8000, 16'hFFFF, 16'h0000, 1'b0, 1'b0, 1'b0, "R7 short overflow", 1'b0);
    runOp(2'd0, 16'h8000, 16'd1, 16'h0000, 1'b0, 1'b0, 1'b0, "R7 short min", 1'b0);

    // R2 / R6: unsigned extended divide
    runOp(2'd1, 16'h3456, 16'h0100, 16'h0012, 1'b0, 1'b0, 1'b0, "R2 basic", 1'b0);
    runOp(2'd1, 16'h0000, 16'd2, 16'h0001, 1'b0, 1'b0, 1'b0, "R5 bit15 quotient", 1'b0);
    runOp(2'd1, 16'hFFFF, 16'd1, 16'hFFFF, 1'b0, 1'b0, 1'b0, "R6 overflow", 1'b0);
    runOp(2'd1, 16'hFFFF, 16'hFFFF, 16'hFFFE, 1'b0, 1'b0, 1'b0, "R6 max fit", 1'b0);

    // R3 / R7: signed extended divide
    runOp(2'd2, 16'hBDC0, 16'd1000, 16'hFFF0, 1'b0, 1'b0, 1'b0, "R3 neg/pos", 1'b0);
    runOp(2'd2, 16'hBDBF, -16'sd1000, 16'hFFF0, 1'b0, 1'b0, 1'b0, "R3 neg/neg", 1'b0);
    runOp(2'd2, 16'h1170, 16'd3, 16'h0001, 1'b0, 1'b0, 1'b0, "R3 pos/pos", 1'b0);
    runOp(2'd2, 16'h0000, 16'hFFFF, 16'h8000, 1'b0, 1'b0, 1'b0, "R7 ext overflow", 1'b0);
    runOp(2'd2, 16'h0000, 16'd2, 16'hFFFF, 1'b0, 1'b0, 1'b0, "R7 ext at min", 1'b0);
    runOp(2'd3, 16'hFF9C, 16'd7, 16'hFFFF, 1'b0, 1'b0, 1'b0, "R3 code3", 1'b0);

    // R4: zero divisor for every operation code
    runOp(2'd0, 16'h1234, 16'h0000, 16'h5678, 1'b1, 1'b0, 1'b1, "R4 short", 1'b0);
    runOp(2'd1, 16'hABCD, 16'h0000, 16'h0042, 1'b0, 1'b1, 1'b0, "R4 unsigned", 1'b0);
    runOp(2'd2, 16'h0F0F, 16'h0000, 16'hF0F0, 1'b1, 1'b1, 1'b1, "R4 signed", 1'b0);

    // R9: start while busy is ignored
    runOp(2'd1, 16'h0000, 16'h0010, 16'h0001, 1'b0, 1'b0, 1'b0, "R9 ignore start", 1'b1);
    runOp(2'd0, -16'sd9, 16'd2, 16'h7777, 1'b0, 1'b0, 1'b0, "R9 after ignore", 1'b0);

    @(negedge clk);
    check("R8", "done low after pulse", longint'(done), 0);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule